// File: doc/BRIEF.md
# TDM Time-Slot and Sub-Slot Assigner

This block connects four line transceivers to frame-synchronised serial TDM ports. All B1 and B2 bearer bytes share one serial input and one serial output. The D signalling channels use a second, separate serial pair. A bit counter starts at each frame sync. Each line owns six assignment entries, one per channel and direction. Each entry holds an enable flag and a position number.

B channels go into 8-bit slots, addressed 0 to 63. D channels go into 2-bit sub-slots, addressed 0 to 255, on their own port. Toward the TDM bus, the block latches a parallel byte or dibit from the line side at the start of its slot and shifts it out MSB first. From the TDM bus, it samples serial bits on the falling bit-clock edge and assembles them MSB first. It then hands the result to the line side with a one-cycle valid strobe.

Top module: `tdm_slot_mapper`

## Requirements
- R1: While `rstN` is low, and just after it is released, `sdBOe`, `sdDOe`, `sdBOut`, `sdDOut` and every valid strobe are 0. All assignment entries are disabled.
- R2: A frame begins on the first rising clock edge at which `frameSync` is sampled high after being sampled low. The bit period that starts at that edge is bit 0 of slot 0 and of sub-slot 0.
- R3: For an enabled serial-out B entry with slot S, the line's byte is latched at the rising edge that starts bit 8·S. It is driven MSB first on `sdBOut` for the 8 bit periods of the slot, with `sdBOe` high for exactly those periods.
- R4: For an enabled serial-out D entry with sub-slot U, the line's dibit is latched at the edge that starts bit 2·U. It is driven MSB first on `sdDOut`, with `sdDOe` high for those 2 bit periods.
- R5: For an enabled serial-in B entry, `sdBIn` is sampled on the falling edge in each bit period of the slot. The bits are assembled MSB first. The byte appears with a valid pulse of exactly one cycle, starting at the rising edge that ends the slot.
- R6: For an enabled serial-in D entry, the two bits of the sub-slot are assembled MSB first and presented with a one-cycle valid pulse, starting at the edge that ends the sub-slot.
- R7: An entry written with `cfgEnable`=0 neither drives its port nor produces a valid strobe, even when its number matches the current position.
- R8: When several enabled serial-out entries claim the same position, the lowest line wins. Within a line, B1 wins over B2. Exactly one source is shifted out.
- R9: Before the first frame sync, and in every bit period with no enabled owner, the output enable is 0 and the output data bit is 0.
- R10: A frame is 512 bit periods long. Without a new sync the count wraps to bit 0. A sync seen mid-frame restarts the count at bit 0.
- R11: A write with `cfgWe`=1 stores `cfgEnable` and `cfgNum` into the entry of line `cfgLine` chosen by `cfgSel`. The codes are: 0 B1 out, 1 B2 out, 2 D out, 3 B1 in, 4 B2 in, 5 D in. B entries use `cfgNum[5:0]`. Several serial-in entries may share a slot, and each of them receives the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame sync |
| cfgWe | input | 1 | Assignment write strobe |
| cfgLine | input | 2 | Line selected by the write |
| cfgSel | input | 3 | Entry code (0..5) |
| cfgEnable | input | 1 | Enable flag written |
| cfgNum | input | 8 | Slot or sub-slot number written |
| sdBIn | input | 1 | Serial B input |
| sdBOut | output | 1 | Serial B output data |
| sdBOe | output | 1 | Serial B output enable |
| sdDIn | input | 1 | Serial D input |
| sdDOut | output | 1 | Serial D output data |
| sdDOe | output | 1 | Serial D output enable |
| b1ToTdm | input | 32 | Per-line B1 bytes to send, line n at [8n+7:8n] |
| b2ToTdm | input | 32 | Per-line B2 bytes to send |
| dToTdm | input | 8 | Per-line D dibits to send, line n at [2n+1:2n] |
| b1FromTdm | output | 32 | Per-line received B1 bytes |
| b1FromTdmVld | output | 4 | B1 byte valid pulses |
| b2FromTdm | output | 32 | Per-line received B2 bytes |
| b2FromTdmVld | output | 4 | B2 byte valid pulses |
| dFromTdm | output | 8 | Per-line received D dibits |
| dFromTdmVld | output | 4 | D dibit valid pulses |

## Verification
On every cycle, the assertions check four things: the counter lands on bit 0 after a frame start; output enables rise only on slot or sub-slot boundaries; valid pulses last one cycle and fall on the last bit of a slot; and at most one serial-out owner is ever selected. Only the bench's scenarios can show whether the right bits land on the wire. That covers MSB-first order, latching at the slot start, capture of falling-edge samples into the right line, priority between conflicting entries, disabled entries staying silent, and restart on a mid-frame sync. The bench shows these by running a behavioural frame model in step with the design and comparing against it every clock.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;

  localparam int NUM_ASSIGN = 6;

  typedef enum logic [2:0] {
    SEL_B1_OUT = 3'd0,
    SEL_B2_OUT = 3'd1,
    SEL_D_OUT  = 3'd2,
    SEL_B1_IN  = 3'd3,
    SEL_B2_IN  = 3'd4,
    SEL_D_IN   = 3'd5
  } cfgSel_e;

  typedef struct packed {
    logic frameStart;
    logic framed;
    logic bDrive;
    logic bLoad;
    logic dDrive;
    logic dLoad;
    logic bSlotEnd;
    logic dSubEnd;
  } tdmStrobes_t;

endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_map_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned FRAME_SLOTS = 64,
  parameter int unsigned SLOT_BITS   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameSync,
  input  logic cfgWe,
  input  logic [((NUM_LINES > 1) ? $clog2(NUM_LINES) : 1)-1:0] cfgLine,
  input  logic [2:0] cfgSel,
  input  logic cfgEnable,
  input  logic [$clog2(FRAME_SLOTS*SLOT_BITS)-2:0] cfgNum,
  output tdmStrobes_t strobes,
  output logic [2*NUM_LINES-1:0] bOwnSel,
  output logic [NUM_LINES-1:0] dOwnSel,
  output logic [NUM_LINES-1:0] rxB1Hit,
  output logic [NUM_LINES-1:0] rxB2Hit,
  output logic [NUM_LINES-1:0] rxDHit,
  output logic [$clog2(FRAME_SLOTS*SLOT_BITS)-1:0] bitIdx
);

  localparam int unsigned FRAME_BITS = FRAME_SLOTS * SLOT_BITS;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned BIT_W      = $clog2(SLOT_BITS);
  localparam int unsigned SLOT_W     = IDX_W - BIT_W;
  localparam int unsigned SUB_W      = IDX_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic fsPrev;
  logic framed;
  logic frameStart;
  logic running;
  logic [IDX_W-1:0] nextIdx;
  logic [NUM_ASSIGN-1:0][NUM_LINES-1:0] asgEn;
  logic [NUM_ASSIGN-1:0][NUM_LINES-1:0][SUB_W-1:0] asgNum;
  logic bFound;
  logic dFound;

  assign frameStart = frameSync & ~fsPrev;
  assign running    = frameStart | framed;

  always_comb begin
    if (frameStart)              nextIdx = '0;
    else if (bitIdx == LAST_IDX) nextIdx = '0;
    else                         nextIdx = bitIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev <= 1'b0;
      framed <= 1'b0;
      bitIdx <= '0;
      asgEn  <= '0;
      asgNum <= '0;
    end else begin
      fsPrev <= frameSync;
      if (frameStart) framed <= 1'b1;
      if (running) bitIdx <= nextIdx;
      if (cfgWe && (int'(cfgSel) < NUM_ASSIGN) && (int'(cfgLine) < int'(NUM_LINES))) begin
        asgEn[cfgSel][cfgLine]  <= cfgEnable;
        asgNum[cfgSel][cfgLine] <= cfgNum;
      end
    end
  end

  // Serial-out owners: resolved for the bit period that the coming edge starts
  always_comb begin
    bOwnSel = '0;
    bFound  = 1'b0;
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      for (int c = 0; c < 2; c++) begin
        if (!bFound && asgEn[int'(SEL_B1_OUT)+c][l] &&
            (asgNum[int'(SEL_B1_OUT)+c][l][SLOT_W-1:0] == nextIdx[IDX_W-1:BIT_W])) begin
          bOwnSel[l*2+c] = 1'b1;
          bFound = 1'b1;
        end
      end
    end
  end

  always_comb begin
    dOwnSel = '0;
    dFound  = 1'b0;
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      if (!dFound && asgEn[int'(SEL_D_OUT)][l] &&
          (asgNum[int'(SEL_D_OUT)][l] == nextIdx[IDX_W-1:1])) begin
        dOwnSel[l] = 1'b1;
        dFound = 1'b1;
      end
    end
  end

  // Serial-in hits: evaluated for the bit period that is ending
  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_rxHit
      assign rxB1Hit[l] = framed && asgEn[int'(SEL_B1_IN)][l] &&
                          (asgNum[int'(SEL_B1_IN)][l][SLOT_W-1:0] == bitIdx[IDX_W-1:BIT_W]);
      assign rxB2Hit[l] = framed && asgEn[int'(SEL_B2_IN)][l] &&
                          (asgNum[int'(SEL_B2_IN)][l][SLOT_W-1:0] == bitIdx[IDX_W-1:BIT_W]);
      assign rxDHit[l]  = framed && asgEn[int'(SEL_D_IN)][l] &&
                          (asgNum[int'(SEL_D_IN)][l] == bitIdx[IDX_W-1:1]);
    end
  endgenerate

  always_comb begin
    strobes.frameStart = frameStart;
    strobes.framed     = framed;
    strobes.bDrive     = running & bFound;
    strobes.bLoad      = running & bFound & (nextIdx[BIT_W-1:0] == '0);
    strobes.dDrive     = running & dFound;
    strobes.dLoad      = running & dFound & ~nextIdx[0];
    strobes.bSlotEnd   = &bitIdx[BIT_W-1:0];
    strobes.dSubEnd    = bitIdx[0];
  end

endmodule

// File: rtl/tdm_slot_dpath.sv
module tdm_slot_dpath
  import tdm_map_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdBIn,
  input  logic sdDIn,
  input  tdmStrobes_t strobes,
  input  logic [2*NUM_LINES-1:0] bOwnSel,
  input  logic [NUM_LINES-1:0] dOwnSel,
  input  logic [NUM_LINES-1:0] rxB1Hit,
  input  logic [NUM_LINES-1:0] rxB2Hit,
  input  logic [NUM_LINES-1:0] rxDHit,
  input  logic [NUM_LINES*SLOT_BITS-1:0] b1ToTdm,
  input  logic [NUM_LINES*SLOT_BITS-1:0] b2ToTdm,
  input  logic [NUM_LINES*2-1:0] dToTdm,
  output logic sdBOut,
  output logic sdBOe,
  output logic sdDOut,
  output logic sdDOe,
  output logic [NUM_LINES*SLOT_BITS-1:0] b1FromTdm,
  output logic [NUM_LINES-1:0] b1FromTdmVld,
  output logic [NUM_LINES*SLOT_BITS-1:0] b2FromTdm,
  output logic [NUM_LINES-1:0] b2FromTdmVld,
  output logic [NUM_LINES*2-1:0] dFromTdm,
  output logic [NUM_LINES-1:0] dFromTdmVld
);

  logic bSample;
  logic dSample;
  logic [SLOT_BITS-1:0] bShift;
  logic [1:0] dShift;
  logic [SLOT_BITS-1:0] bPick;
  logic [1:0] dPick;
  logic bOeQ;
  logic dOeQ;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      bSample <= 1'b0;
      dSample <= 1'b0;
    end else begin
      bSample <= sdBIn;
      dSample <= sdDIn;
    end
  end

  always_comb begin
    bPick = '0;
    dPick = '0;
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      if (bOwnSel[l*2])   bPick = bPick | b1ToTdm[l*SLOT_BITS +: SLOT_BITS];
      if (bOwnSel[l*2+1]) bPick = bPick | b2ToTdm[l*SLOT_BITS +: SLOT_BITS];
      if (dOwnSel[l])     dPick = dPick | dToTdm[l*2 +: 2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bShift <= '0;
      dShift <= '0;
      bOeQ   <= 1'b0;
      dOeQ   <= 1'b0;
    end else begin
      bOeQ <= strobes.bDrive;
      dOeQ <= strobes.dDrive;
      if (strobes.bLoad) bShift <= bPick;
      else               bShift <= {bShift[SLOT_BITS-2:0], 1'b0};
      if (strobes.dLoad) dShift <= dPick;
      else               dShift <= {dShift[0], 1'b0};
    end
  end

  assign sdBOe  = bOeQ;
  assign sdDOe  = dOeQ;
  assign sdBOut = bOeQ & bShift[SLOT_BITS-1];
  assign sdDOut = dOeQ & dShift[1];

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_cap
      logic [1:0] bHit;
      logic [1:0][SLOT_BITS-1:0] bCap;
      logic [1:0][SLOT_BITS-1:0] bByteQ;
      logic [1:0] bVldQ;
      logic [1:0] dCap;
      logic [1:0] dByteQ;
      logic dVldQ;

      assign bHit = {rxB2Hit[l], rxB1Hit[l]};

      for (genvar c = 0; c < 2; c++) begin : g_ch
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            bCap[c]   <= '0;
            bByteQ[c] <= '0;
            bVldQ[c]  <= 1'b0;
          end else begin
            bVldQ[c] <= bHit[c] & strobes.bSlotEnd;
            if (bHit[c]) begin
              bCap[c] <= {bCap[c][SLOT_BITS-2:0], bSample};
              if (strobes.bSlotEnd) bByteQ[c] <= {bCap[c][SLOT_BITS-2:0], bSample};
            end
          end
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dCap   <= '0;
          dByteQ <= '0;
          dVldQ  <= 1'b0;
        end else begin
          dVldQ <= rxDHit[l] & strobes.dSubEnd;
          if (rxDHit[l]) begin
            dCap <= {dCap[0], dSample};
            if (strobes.dSubEnd) dByteQ <= {dCap[0], dSample};
          end
        end
      end

      assign b1FromTdm[l*SLOT_BITS +: SLOT_BITS] = bByteQ[0];
      assign b2FromTdm[l*SLOT_BITS +: SLOT_BITS] = bByteQ[1];
      assign b1FromTdmVld[l] = bVldQ[0];
      assign b2FromTdmVld[l] = bVldQ[1];
      assign dFromTdm[l*2 +: 2] = dByteQ;
      assign dFromTdmVld[l] = dVldQ;
    end
  endgenerate

endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
  import tdm_map_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned FRAME_SLOTS = 64,
  parameter int unsigned SLOT_BITS   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameSync,
  input  logic cfgWe,
  input  logic [((NUM_LINES > 1) ? $clog2(NUM_LINES) : 1)-1:0] cfgLine,
  input  logic [2:0] cfgSel,
  input  logic cfgEnable,
  input  logic [$clog2(FRAME_SLOTS*SLOT_BITS)-2:0] cfgNum,
  input  logic sdBIn,
  output logic sdBOut,
  output logic sdBOe,
  input  logic sdDIn,
  output logic sdDOut,
  output logic sdDOe,
  input  logic [NUM_LINES*SLOT_BITS-1:0] b1ToTdm,
  input  logic [NUM_LINES*SLOT_BITS-1:0] b2ToTdm,
  input  logic [NUM_LINES*2-1:0] dToTdm,
  output logic [NUM_LINES*SLOT_BITS-1:0] b1FromTdm,
  output logic [NUM_LINES-1:0] b1FromTdmVld,
  output logic [NUM_LINES*SLOT_BITS-1:0] b2FromTdm,
  output logic [NUM_LINES-1:0] b2FromTdmVld,
  output logic [NUM_LINES*2-1:0] dFromTdm,
  output logic [NUM_LINES-1:0] dFromTdmVld
);

  localparam int unsigned IDX_W = $clog2(FRAME_SLOTS*SLOT_BITS);

  tdmStrobes_t ctlStrobes;
  logic [2*NUM_LINES-1:0] bOwnSel;
  logic [NUM_LINES-1:0] dOwnSel;
  logic [NUM_LINES-1:0] rxB1Hit;
  logic [NUM_LINES-1:0] rxB2Hit;
  logic [NUM_LINES-1:0] rxDHit;
  logic [IDX_W-1:0] bitIdx;

  tdm_slot_ctrl #(
    .NUM_LINES(NUM_LINES), .FRAME_SLOTS(FRAME_SLOTS), .SLOT_BITS(SLOT_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .cfgWe(cfgWe), .cfgLine(cfgLine), .cfgSel(cfgSel),
    .cfgEnable(cfgEnable), .cfgNum(cfgNum),
    .strobes(ctlStrobes), .bOwnSel(bOwnSel), .dOwnSel(dOwnSel),
    .rxB1Hit(rxB1Hit), .rxB2Hit(rxB2Hit), .rxDHit(rxDHit), .bitIdx(bitIdx)
  );

  tdm_slot_dpath #(
    .NUM_LINES(NUM_LINES), .SLOT_BITS(SLOT_BITS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .sdBIn(sdBIn), .sdDIn(sdDIn),
    .strobes(ctlStrobes), .bOwnSel(bOwnSel), .dOwnSel(dOwnSel),
    .rxB1Hit(rxB1Hit), .rxB2Hit(rxB2Hit), .rxDHit(rxDHit),
    .b1ToTdm(b1ToTdm), .b2ToTdm(b2ToTdm), .dToTdm(dToTdm),
    .sdBOut(sdBOut), .sdBOe(sdBOe), .sdDOut(sdDOut), .sdDOe(sdDOe),
    .b1FromTdm(b1FromTdm), .b1FromTdmVld(b1FromTdmVld),
    .b2FromTdm(b2FromTdm), .b2FromTdmVld(b2FromTdmVld),
    .dFromTdm(dFromTdm), .dFromTdmVld(dFromTdmVld)
  );

endmodule

// File: rtl/tdm_slot_mapper_chk.sv
module tdm_slot_mapper_chk
  import tdm_map_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned FRAME_SLOTS = 64,
  parameter int unsigned SLOT_BITS   = 8
) (
  input logic clk,
  input logic rstN,
  input tdmStrobes_t strobes,
  input logic [$clog2(FRAME_SLOTS*SLOT_BITS)-1:0] bitIdx,
  input logic [2*NUM_LINES-1:0] bOwnSel,
  input logic [NUM_LINES-1:0] dOwnSel,
  input logic sdBOe,
  input logic sdDOe,
  input logic [NUM_LINES-1:0] b1Vld,
  input logic [NUM_LINES-1:0] b2Vld,
  input logic [NUM_LINES-1:0] dVld
);

  localparam int unsigned BIT_W = $clog2(SLOT_BITS);
  localparam logic [BIT_W-1:0] BIT_MAX = '1;

  p_frame_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameStart |=> (bitIdx == '0));

  p_b_slot_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdBOe) |-> (bitIdx[BIT_W-1:0] == '0));

  p_d_sub_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdDOe) |-> !bitIdx[0]);

  p_b_vld_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|{b1Vld, b2Vld}) |-> ($past(bitIdx[BIT_W-1:0]) == BIT_MAX));

  p_b_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|{b1Vld, b2Vld}) |=> ((b1Vld & $past(b1Vld)) == '0) && ((b2Vld & $past(b2Vld)) == '0));

  p_d_vld_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|dVld) |-> $past(bitIdx[0]));

  p_one_owner_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bOwnSel) && $onehot0(dOwnSel));

  p_idle_unframed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.framed && !strobes.frameStart) |=> (!sdBOe && !sdDOe));

endmodule

bind tdm_slot_mapper tdm_slot_mapper_chk #(
  .NUM_LINES(NUM_LINES), .FRAME_SLOTS(FRAME_SLOTS), .SLOT_BITS(SLOT_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .strobes(ctlStrobes), .bitIdx(bitIdx),
  .bOwnSel(bOwnSel), .dOwnSel(dOwnSel), .sdBOe(sdBOe), .sdDOe(sdDOe),
  .b1Vld(b1FromTdmVld), .b2Vld(b2FromTdmVld), .dVld(dFromTdmVld)
);

// File: tb/tdm_slot_mapper_bench.sv
module tdm_slot_mapper_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int FBITS = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgLine = '0;
  logic [2:0] cfgSel = '0;
  logic cfgEnable = 1'b0;
  logic [7:0] cfgNum = '0;
  logic sdBIn = 1'b0, sdDIn = 1'b0;
  logic sdBOut, sdBOe, sdDOut, sdDOe;
  logic [NL*8-1:0] b1ToTdm = '0, b2ToTdm = '0;
  logic [NL*2-1:0] dToTdm = '0;
  logic [NL*8-1:0] b1FromTdm, b2FromTdm;
  logic [NL-1:0] b1FromTdmVld, b2FromTdmVld, dFromTdmVld;
  logic [NL*2-1:0] dFromTdm;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_mapper u_tdm_slot_mapper (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .cfgWe(cfgWe), .cfgLine(cfgLine), .cfgSel(cfgSel), .cfgEnable(cfgEnable), .cfgNum(cfgNum),
    .sdBIn(sdBIn), .sdBOut(sdBOut), .sdBOe(sdBOe),
    .sdDIn(sdDIn), .sdDOut(sdDOut), .sdDOe(sdDOe),
    .b1ToTdm(b1ToTdm), .b2ToTdm(b2ToTdm), .dToTdm(dToTdm),
    .b1FromTdm(b1FromTdm), .b1FromTdmVld(b1FromTdmVld),
    .b2FromTdm(b2FromTdm), .b2FromTdmVld(b2FromTdmVld),
    .dFromTdm(dFromTdm), .dFromTdmVld(dFromTdmVld)
  );

  int nChecks = 0;
  int nFails = 0;

  // behavioural frame model
  int mIdx = 0;
  bit mFramed = 0, mFsPrev = 0, mFsStart = 0;
  bit cEn[6][NL];
  int cNum[6][NL];
  int mCapB[NL][2], mByteB[NL][2];
  bit mVldB[NL][2];
  int mCapD[NL], mByteD[NL];
  bit mVldD[NL];
  int mBLatch = 0, mDLatch = 0;
  bit mBOe = 0, mBOut = 0, mDOe = 0, mDOut = 0;
  int bCands = 0, dCands = 0;
  bit bDis = 0, dDis = 0;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int bOwn, dOwn;
    // serial-in capture uses the bit period that is ending
    for (int l = 0; l < NL; l++) begin
      for (int c = 0; c < 2; c++) begin
        mVldB[l][c] = 0;
        if (mFramed && cEn[3+c][l] && (cNum[3+c][l] % 64) == mIdx / 8) begin
          mCapB[l][c] = ((mCapB[l][c] << 1) | int'(sdBIn)) & 255;
          if (mIdx % 8 == 7) begin mVldB[l][c] = 1; mByteB[l][c] = mCapB[l][c]; end
        end
      end
      mVldD[l] = 0;
      if (mFramed && cEn[5][l] && cNum[5][l] == mIdx / 2) begin
        mCapD[l] = ((mCapD[l] << 1) | int'(sdDIn)) & 3;
        if (mIdx % 2 == 1) begin mVldD[l] = 1; mByteD[l] = mCapD[l]; end
      end
    end
    mFsStart = frameSync && !mFsPrev;
    mFsPrev = frameSync;
    if (mFsStart) begin mIdx = 0; mFramed = 1; end
    else if (mFramed) mIdx = (mIdx + 1) % FBITS;
    bOwn = -1; dOwn = -1; bCands = 0; dCands = 0; bDis = 0; dDis = 0;
    for (int l = 0; l < NL; l++) begin
      for (int c = 0; c < 2; c++) begin
        if ((cNum[c][l] % 64) == mIdx / 8) begin
          if (cEn[c][l]) begin bCands++; if (bOwn < 0) bOwn = l*2 + c; end
          else bDis = 1;
        end
      end
      if (cNum[2][l] == mIdx / 2) begin
        if (cEn[2][l]) begin dCands++; if (dOwn < 0) dOwn = l; end
        else dDis = 1;
      end
    end
    if (mFramed && bOwn >= 0) begin
      if (mIdx % 8 == 0)
        mBLatch = (bOwn % 2 == 0) ? int'(b1ToTdm[(bOwn/2)*8 +: 8]) : int'(b2ToTdm[(bOwn/2)*8 +: 8]);
      mBOe = 1; mBOut = bit'((mBLatch >> (7 - mIdx % 8)) & 1);
    end else begin mBOe = 0; mBOut = 0; end
    if (mFramed && dOwn >= 0) begin
      if (mIdx % 2 == 0) mDLatch = int'(dToTdm[dOwn*2 +: 2]);
      mDOe = 1; mDOut = bit'((mDLatch >> (1 - mIdx % 2)) & 1);
    end else begin mDOe = 0; mDOut = 0; end
    if (cfgWe) begin
      cEn[cfgSel][cfgLine] = cfgEnable;
      cNum[cfgSel][cfgLine] = int'(cfgNum);
    end
  endtask

  task automatic compareAll();
    string tb, td;
    tb = !mFramed ? "R9" : (bCands > 1 ? "R8" : (bDis && !mBOe ? "R7" : (mBOe ? "R3" : "R9")));
    td = !mFramed ? "R9" : (dCands > 1 ? "R8" : (dDis && !mDOe ? "R7" : (mDOe ? "R4" : "R9")));
    chk(tb, int'(sdBOe), int'(mBOe));
    chk(tb, int'(sdBOut), int'(mBOut));
    chk(td, int'(sdDOe), int'(mDOe));
    chk(td, int'(sdDOut), int'(mDOut));
    for (int l = 0; l < NL; l++) begin
      chk((l == 2) ? "R7" : "R5", int'(b1FromTdmVld[l]), int'(mVldB[l][0]));
      chk((l == 2) ? "R7" : "R5", int'(b2FromTdmVld[l]), int'(mVldB[l][1]));
      if (mVldB[l][0]) chk("R5", int'(b1FromTdm[l*8 +: 8]), mByteB[l][0]);
      if (mVldB[l][1]) chk("R5", int'(b2FromTdm[l*8 +: 8]), mByteB[l][1]);
      chk((l == 1) ? "R7" : "R6", int'(dFromTdmVld[l]), int'(mVldD[l]));
      if (mVldD[l]) chk("R6", int'(dFromTdm[l*2 +: 2]), mByteD[l]);
    end
    if (mFsStart) begin
      chk("R2", int'(sdDOe), 1);
      chk("R2", int'(sdDOut), int'(dToTdm[1]));
    end
    if (mFramed && mIdx == 16) chk("R10", int'(sdBOe), 1);
    if (b1FromTdmVld[0] && b2FromTdmVld[1])
      chk("R11", int'(b2FromTdm[15:8]), int'(b1FromTdm[7:0]));
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    modelStep();
    compareAll();
    sdBIn = 1'($urandom_range(0, 1));
    sdDIn = 1'($urandom_range(0, 1));
    b1ToTdm = $urandom;
    b2ToTdm = $urandom;
    dToTdm = 8'($urandom);
  endtask

  task automatic wr(int sel, int line, bit en, int num);
    cfgWe = 1'b1; cfgSel = 3'(sel); cfgLine = 2'(line); cfgEnable = en; cfgNum = 8'(num);
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int a = 0; a < 6; a++)
      for (int l = 0; l < NL; l++) begin cEn[a][l] = 0; cNum[a][l] = 0; end
    for (int l = 0; l < NL; l++) begin
      mCapD[l] = 0; mByteD[l] = 0; mVldD[l] = 0;
      for (int c = 0; c < 2; c++) begin mCapB[l][c] = 0; mByteB[l][c] = 0; mVldB[l][c] = 0; end
    end
    // R1: reset state
    repeat (3) begin
      @(posedge clk); #2;
      chk("R1", int'(sdBOe), 0);
      chk("R1", int'(sdDOe), 0);
      chk("R1", int'(sdBOut), 0);
      chk("R1", int'({b1FromTdmVld, b2FromTdmVld, dFromTdmVld}), 0);
    end
    rstN = 1'b1;
    tick();
    chk("R1", int'(sdBOe | sdDOe), 0);
    // R11: assignment writes (codes 0..5)
    wr(0, 0, 1, 2);   wr(0, 1, 1, 2);   wr(1, 0, 1, 5);
    wr(0, 2, 1, 5);   wr(1, 2, 1, 7);   wr(0, 3, 0, 9);
    wr(0, 1, 1, 2);   wr(1, 1, 1, 2);   wr(1, 3, 1, 12);
    wr(0, 3, 1, 12);  wr(0, 3, 0, 9);   wr(0, 1, 1, 2);
    wr(1, 1, 1, 12);  wr(0, 1, 1, 12);  wr(0, 1, 1, 2);
    wr(0, 2, 1, 5);   wr(0, 3, 0, 9);
    wr(2, 0, 1, 0);   wr(2, 1, 1, 0);   wr(2, 3, 1, 255); wr(2, 2, 0, 100);
    wr(3, 0, 1, 2);   wr(4, 1, 1, 2);   wr(3, 3, 1, 63);  wr(4, 2, 0, 4);
    wr(5, 0, 1, 3);   wr(5, 2, 1, 255); wr(5, 1, 0, 10);
    // R9: idle before first sync
    repeat (10) tick();
    // R2: first frame
    frameSync = 1'b1; tick(); frameSync = 1'b0;
    repeat (FBITS - 1) tick();
    // second frame at the natural boundary
    frameSync = 1'b1; tick(); frameSync = 1'b0;
    repeat (200) tick();
    // R10: mid-frame restart, then free-running wrap
    frameSync = 1'b1; tick(); frameSync = 1'b0;
    repeat (FBITS + 120) tick();
    summary();
    $finish;
  end

endmodule